// File: doc/BRIEF.md
# Multi-mode complex arithmetic datapath

This block is a one-result-per-cycle arithmetic cluster for complex samples in a baseband processor. Three complex operands A, B and C arrive together, each with signed N-bit real and imaginary parts. A 2-bit mode input picks the operation for that cycle: a radix-2 decimation-in-time butterfly with C as the twiddle factor, a plain complex product, a complex multiply-accumulate, or a complex sum or difference. A single bank of four N×N real multipliers and one set of adders serve every mode.

Operands are read as Q1.(N-1) fractions. Products therefore sit at 2N-bit width with 2N-2 fraction bits. Wherever B or A is combined with a product or with each other, the operand is aligned to that fraction position by a left shift of N-1. Every result is saturated to 2N signed bits and registered. The output valid follows the input valid one cycle later. Two accumulators, one for the real part and one for the imaginary part, each carry four guard bits above 2N. Software sequences MAC runs with a clear pulse or a load-first flag.

Top module: `cplx_dp_cluster`

## Requirements
- R1: The mode input is decoded as 2'b00 butterfly, 2'b01 multiply, 2'b10 multiply-accumulate, 2'b11 add/subtract.
- R2: In multiply mode, y0 carries the complex product A×C, with real part AR·CR−AI·CI and imaginary part AR·CI+AI·CR, and y1 is zero in both parts.
- R3: In butterfly mode, y0 = B·2^(N-1) + A×C and y1 = B·2^(N-1) − A×C, both real and imaginary, in the same cycle.
- R4: In multiply-accumulate mode with in_valid high, each accumulator adds the matching part of A×C at 2N+4-bit width, and y0 shows the new accumulator value after saturation. y1 is zero.
- R5: When load_first is high during a multiply-accumulate, the accumulators take the current product and drop their old contents.
- R6: A high clr sets both accumulators to zero at the next edge, whether or not in_valid is high and in any mode. It takes priority over accumulation, so a multiply-accumulate issued with clr reports zero.
- R7: In add/subtract mode, y0 = (A+B)·2^(N-1), or (A−B)·2^(N-1) when sub is high, and y1 is zero.
- R8: Each output part is clipped to the signed 2N-bit range. ovf is high for a result in which any of the four parts was clipped. The accumulators keep their unclipped value.
- R9: out_valid is in_valid delayed by one clock. Outputs and ovf change only for a cycle with in_valid high, and they hold otherwise.
- R10: During reset and after it, outputs, ovf, out_valid and both accumulators are zero.
- R11: The accumulators hold their value across cycles in other modes, so a multiply-accumulate run can be interleaved with other operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | Operation select (see R1) |
| sub | input | 1 | Add/subtract mode: 1 selects A−B |
| clr | input | 1 | Synchronous accumulator clear |
| load_first | input | 1 | Start a new accumulation from the current product |
| a_re | input | N | Operand A, real part |
| a_im | input | N | Operand A, imaginary part |
| b_re | input | N | Operand B, real part |
| b_im | input | N | Operand B, imaginary part |
| c_re | input | N | Operand C (twiddle), real part |
| c_im | input | N | Operand C (twiddle), imaginary part |
| out_valid | output | 1 | Result registers hold a new result |
| y0_re | output | 2N | First result, real part |
| y0_im | output | 2N | First result, imaginary part |
| y1_re | output | 2N | Second result (butterfly difference), real part |
| y1_im | output | 2N | Second result (butterfly difference), imaginary part |
| ovf | output | 1 | Saturation occurred in the registered result |

## Verification
Most internal faults show one cycle after the triggering operation. A swapped partial-product pairing or a wrong sign in the combining adders corrupts y0 of the first multiply or butterfly that uses asymmetric operands. A mis-aligned B shifts the butterfly sum by a power of two.

Accumulator faults stay hidden until the next multiply-accumulate. A missed clear, a load-first that adds, or an accumulator that drifts during other modes shows on y0 of the next MAC result. Guard-bit loss shows only after a saturated run is brought back into range. The tests include that sequence, so such a fault is seen a few cycles after it occurs.

// File: rtl/cplx_pkg.sv
package cplx_pkg;

  typedef enum logic [1:0] {
    MODE_BFLY   = 2'b00,
    MODE_MUL    = 2'b01,
    MODE_MAC    = 2'b10,
    MODE_ADDSUB = 2'b11
  } cplx_mode_e;

  localparam int LANE_RE = 0;
  localparam int LANE_IM = 1;
  localparam int LANES   = 2;
  localparam int RESULTS = 2;

endpackage

// File: rtl/cplx_rst_sync.sv
module cplx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cplx_mult.sv
module cplx_mult #(
  parameter int N = 16,
  localparam int PROD_W = 2 * N,
  localparam int SUM_W  = 2 * N + 1
) (
  input  logic [N-1:0]     a_re,
  input  logic [N-1:0]     a_im,
  input  logic [N-1:0]     c_re,
  input  logic [N-1:0]     c_im,
  output logic [SUM_W-1:0] p_re,
  output logic [SUM_W-1:0] p_im
);

  localparam int NUM_MULT = 4;
  localparam int PP_RR = 0;
  localparam int PP_II = 1;
  localparam int PP_RI = 2;
  localparam int PP_IR = 3;

  logic signed [N-1:0]      lhs [NUM_MULT];
  logic signed [N-1:0]      rhs [NUM_MULT];
  logic signed [PROD_W-1:0] pp  [NUM_MULT];

  // operand routing for the four partial products
  assign lhs[PP_RR] = a_re;  assign rhs[PP_RR] = c_re;
  assign lhs[PP_II] = a_im;  assign rhs[PP_II] = c_im;
  assign lhs[PP_RI] = a_re;  assign rhs[PP_RI] = c_im;
  assign lhs[PP_IR] = a_im;  assign rhs[PP_IR] = c_re;

  for (genvar g = 0; g < NUM_MULT; g++) begin : g_mult
    assign pp[g] = lhs[g] * rhs[g];
  end

  // one extra bit so that (-1)*(-1) terms summed never wrap
  assign p_re = {pp[PP_RR][PROD_W-1], pp[PP_RR]} - {pp[PP_II][PROD_W-1], pp[PP_II]};
  assign p_im = {pp[PP_RI][PROD_W-1], pp[PP_RI]} + {pp[PP_IR][PROD_W-1], pp[PP_IR]};

endmodule

// File: rtl/cplx_sat.sv
module cplx_sat #(
  parameter int IN_W  = 36,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout,
  output logic             clipped
);

  localparam int TOP_W = IN_W - OUT_W + 1;

  logic [TOP_W-1:0] top_bits;

  assign top_bits = din[IN_W-1:OUT_W-1];

  always_comb begin
    clipped = !((top_bits == '0) || (top_bits == '1));
    if (!clipped) begin
      dout = din[OUT_W-1:0];
    end else if (din[IN_W-1]) begin
      dout = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      dout = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end

endmodule

// File: rtl/cplx_acc.sv
module cplx_acc #(
  parameter int ACC_W = 36,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_en,
  input  logic                        clr,
  input  logic                        load_first,
  input  logic [LANES-1:0][ACC_W-1:0] addend,
  output logic [LANES-1:0][ACC_W-1:0] acc_nxt,
  output logic [LANES-1:0][ACC_W-1:0] acc_q
);

  logic acc_we;

  assign acc_we = clr || acc_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ACC_W-1:0] base;

    always_comb begin
      base       = load_first ? '0 : acc_q[l];
      acc_nxt[l] = acc_q[l];
      if (clr) begin
        acc_nxt[l] = '0;
      end else if (acc_en) begin
        acc_nxt[l] = base + addend[l];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[l] <= '0;
      end else if (acc_we) begin
        acc_q[l] <= acc_nxt[l];
      end
    end
  end

endmodule

// File: rtl/cplx_dp_cluster.sv
module cplx_dp_cluster
  import cplx_pkg::*;
#(
  parameter int N          = 16,
  parameter int RST_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     mode,
  input  logic           sub,
  input  logic           clr,
  input  logic           load_first,
  input  logic [N-1:0]   a_re,
  input  logic [N-1:0]   a_im,
  input  logic [N-1:0]   b_re,
  input  logic [N-1:0]   b_im,
  input  logic [N-1:0]   c_re,
  input  logic [N-1:0]   c_im,
  output logic           out_valid,
  output logic [2*N-1:0] y0_re,
  output logic [2*N-1:0] y0_im,
  output logic [2*N-1:0] y1_re,
  output logic [2*N-1:0] y1_im,
  output logic           ovf
);

  localparam int PW    = 2 * N + 1;
  localparam int OW    = 2 * N;
  localparam int AW    = 2 * N + 4;
  localparam int EXT_P = AW - PW;
  localparam int EXT_Q = AW - (2 * N - 1);
  localparam int FRAC  = N - 1;

  logic       rst_n_sync;
  cplx_mode_e mode_sel;

  cplx_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign mode_sel = cplx_mode_e'(mode);

  // multiplier bank
  logic [PW-1:0] prod_re, prod_im;

  cplx_mult #(.N(N)) mult_i (
    .a_re (a_re),
    .a_im (a_im),
    .c_re (c_re),
    .c_im (c_im),
    .p_re (prod_re),
    .p_im (prod_im)
  );

  // lane-organised operands
  logic [LANES-1:0][N-1:0]  a_l, b_l;
  logic [LANES-1:0][PW-1:0] p_l;
  logic [LANES-1:0][AW-1:0] p_x, a_x, b_x, ab_x;
  logic [LANES-1:0][AW-1:0] acc_nxt, acc_q;
  logic [RESULTS-1:0][LANES-1:0][AW-1:0] wide;
  logic [RESULTS-1:0][LANES-1:0][OW-1:0] y_sat;
  logic [RESULTS-1:0][LANES-1:0]         clip;

  assign a_l = {a_im, a_re};
  assign b_l = {b_im, b_re};
  assign p_l = {prod_im, prod_re};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign p_x[l]  = {{EXT_P{p_l[l][PW-1]}}, p_l[l]};
    assign a_x[l]  = {{EXT_Q{a_l[l][N-1]}}, a_l[l], {FRAC{1'b0}}};
    assign b_x[l]  = {{EXT_Q{b_l[l][N-1]}}, b_l[l], {FRAC{1'b0}}};
    assign ab_x[l] = sub ? (a_x[l] - b_x[l]) : (a_x[l] + b_x[l]);

    always_comb begin
      wide[0][l] = '0;
      wide[1][l] = '0;
      case (mode_sel)
        MODE_BFLY: begin
          wide[0][l] = b_x[l] + p_x[l];
          wide[1][l] = b_x[l] - p_x[l];
        end
        MODE_MUL:    wide[0][l] = p_x[l];
        MODE_MAC:    wide[0][l] = acc_nxt[l];
        MODE_ADDSUB: wide[0][l] = ab_x[l];
        default: begin
          wide[0][l] = '0;
          wide[1][l] = '0;
        end
      endcase
    end

    for (genvar k = 0; k < RESULTS; k++) begin : g_res
      cplx_sat #(.IN_W(AW), .OUT_W(OW)) sat_i (
        .din     (wide[k][l]),
        .dout    (y_sat[k][l]),
        .clipped (clip[k][l])
      );
    end
  end

  // accumulators
  logic acc_en;

  assign acc_en = in_valid && (mode_sel == MODE_MAC);

  cplx_acc #(.ACC_W(AW), .LANES(LANES)) acc_i (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .acc_en     (acc_en),
    .clr        (clr),
    .load_first (load_first),
    .addend     (p_x),
    .acc_nxt    (acc_nxt),
    .acc_q      (acc_q)
  );

  // result registers: next-state
  logic [RESULTS-1:0][LANES-1:0][OW-1:0] y_d, y_q;
  logic ovf_d, ovf_q, vld_q;

  always_comb begin
    y_d   = y_q;
    ovf_d = ovf_q;
    if (in_valid) begin
      y_d   = y_sat;
      ovf_d = |clip;
    end
  end

  // result registers: state
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      y_q   <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      y_q   <= y_d;
      ovf_q <= ovf_d;
      vld_q <= in_valid;
    end
  end

  assign y0_re     = y_q[0][LANE_RE];
  assign y0_im     = y_q[0][LANE_IM];
  assign y1_re     = y_q[1][LANE_RE];
  assign y1_im     = y_q[1][LANE_IM];
  assign ovf       = ovf_q;
  assign out_valid = vld_q;

endmodule

// File: rtl/cplx_dp_cluster_chk.sv
module cplx_dp_cluster_chk #(
  parameter int N = 16,
  localparam int OW = 2 * N,
  localparam int AW = 2 * N + 4
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          in_valid,
  input logic [1:0]    mode,
  input logic          clr,
  input logic [N-1:0]  b_re,
  input logic [N-1:0]  b_im,
  input logic          out_valid,
  input logic [OW-1:0] y0_re,
  input logic [OW-1:0] y0_im,
  input logic [OW-1:0] y1_re,
  input logic [OW-1:0] y1_im,
  input logic          ovf,
  input logic [AW-1:0] acc_re,
  input logic [AW-1:0] acc_im
);

  localparam logic [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

  logic [OW+1:0] ysum_re, ysum_im, bdbl_re, bdbl_im;
  logic          any_extreme;

  assign ysum_re = {{2{y0_re[OW-1]}}, y0_re} + {{2{y1_re[OW-1]}}, y1_re};
  assign ysum_im = {{2{y0_im[OW-1]}}, y0_im} + {{2{y1_im[OW-1]}}, y1_im};
  assign bdbl_re = {{2{b_re[N-1]}}, b_re, {N{1'b0}}};
  assign bdbl_im = {{2{b_im[N-1]}}, b_im, {N{1'b0}}};
  assign any_extreme = (y0_re == MAXV) || (y0_re == MINV) || (y0_im == MAXV) ||
                       (y0_im == MINV) || (y1_re == MAXV) || (y1_re == MINV) ||
                       (y1_im == MAXV) || (y1_im == MINV);

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid |=> out_valid);

  a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> ($stable(y0_re) && $stable(y0_im) && $stable(y1_re) &&
                   $stable(y1_im) && $stable(ovf)));

  a_r2_y1_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && mode != 2'b00) |=> (y1_re == '0 && y1_im == '0));

  a_r3_bfly_sum: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && mode == 2'b00) |=>
      (ovf || (ysum_re == $past(bdbl_re) && ysum_im == $past(bdbl_im))));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (acc_re == '0 && acc_im == '0));

  a_r11_acc_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr && !(in_valid && mode == 2'b10)) |=> ($stable(acc_re) && $stable(acc_im)));

  a_r8_ovf_extreme: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf |-> any_extreme);

endmodule

bind cplx_dp_cluster cplx_dp_cluster_chk #(.N(N)) chk_i (
  .clk       (clk),
  .rst_ni    (rst_n_sync),
  .in_valid  (in_valid),
  .mode      (mode),
  .clr       (clr),
  .b_re      (b_re),
  .b_im      (b_im),
  .out_valid (out_valid),
  .y0_re     (y0_re),
  .y0_im     (y0_im),
  .y1_re     (y1_re),
  .y1_im     (y1_im),
  .ovf       (ovf),
  .acc_re    (acc_q[0]),
  .acc_im    (acc_q[1])
);

// File: tb/cplx_dp_cluster_tb_top.sv
`timescale 1ns/1ps
module cplx_dp_cluster_tb_top;

  localparam int N  = 16;
  localparam int OW = 2 * N;
  localparam int AW = 2 * N + 4;
  localparam longint MAXV = (64'sd1 <<< (OW - 1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (OW - 1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          sub = 1'b0, clr = 1'b0, load_first = 1'b0;
  logic [N-1:0]  a_re = '0, a_im = '0, b_re = '0, b_im = '0, c_re = '0, c_im = '0;
  logic          out_valid, ovf;
  logic [OW-1:0] y0_re, y0_im, y1_re, y1_im;

  int     n_tests = 0;
  int     n_fail  = 0;
  bit     done    = 1'b0;
  longint acc_re_m = 0, acc_im_m = 0;

  always #5 clk = ~clk;

  cplx_dp_cluster #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .sub(sub),
    .clr(clr), .load_first(load_first),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .c_re(c_re), .c_im(c_im),
    .out_valid(out_valid), .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re),
    .y1_im(y1_im), .ovf(ovf)
  );

  function automatic longint wrap_acc(longint v);
    return (v <<< (64 - AW)) >>> (64 - AW);
  endfunction

  function automatic longint sat(longint v, inout bit f);
    if (v > MAXV) begin f = 1'b1; return MAXV; end
    if (v < MINV) begin f = 1'b1; return MINV; end
    return v;
  endfunction

  function automatic longint sx(logic [OW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives one operation, updates the model and checks every output
  task automatic run_op(string tag, int md, bit sb, bit cl, bit lf,
                        int ar, int ai, int br, int bi, int cr, int ci);
    longint pr, pi, w0r, w0i, w1r, w1i, sc;
    bit f;
    sc = 64'sd1 <<< (N - 1);
    pr = longint'(ar) * cr - longint'(ai) * ci;
    pi = longint'(ar) * ci + longint'(ai) * cr;
    w0r = 0; w0i = 0; w1r = 0; w1i = 0;
    if (cl) begin
      acc_re_m = 0; acc_im_m = 0;
    end
    case (md)
      0: begin
        w0r = br * sc + pr; w0i = bi * sc + pi;
        w1r = br * sc - pr; w1i = bi * sc - pi;
      end
      1: begin w0r = pr; w0i = pi; end
      2: begin
        if (!cl) begin
          acc_re_m = wrap_acc((lf ? 0 : acc_re_m) + pr);
          acc_im_m = wrap_acc((lf ? 0 : acc_im_m) + pi);
        end
        w0r = acc_re_m; w0i = acc_im_m;
      end
      default: begin
        w0r = (sb ? longint'(ar) - br : longint'(ar) + br) * sc;
        w0i = (sb ? longint'(ai) - bi : longint'(ai) + bi) * sc;
      end
    endcase
    f = 1'b0;
    w0r = sat(w0r, f); w0i = sat(w0i, f); w1r = sat(w1r, f); w1i = sat(w1i, f);
    mode = md[1:0]; sub = sb; clr = cl; load_first = lf;
    a_re = N'(ar); a_im = N'(ai); b_re = N'(br); b_im = N'(bi);
    c_re = N'(cr); c_im = N'(ci);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0; load_first = 1'b0;
    chk({tag, " out_valid"}, longint'(out_valid), 1);
    chk({tag, " y0_re"}, sx(y0_re), w0r);
    chk({tag, " y0_im"}, sx(y0_im), w0i);
    chk({tag, " y1_re"}, sx(y1_re), w1r);
    chk({tag, " y1_im"}, sx(y1_im), w1i);
    chk({tag, " ovf"}, longint'(ovf), longint'(f));
  endtask

  task automatic clr_pulse();
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    acc_re_m = 0; acc_im_m = 0;
  endtask

  task automatic t_reset();
    chk("R10 out_valid", longint'(out_valid), 0);
    chk("R10 y0_re", sx(y0_re), 0);
    chk("R10 y1_im", sx(y1_im), 0);
    chk("R10 ovf", longint'(ovf), 0);
    // accumulator starts at zero: first MAC without load_first shows the bare product
    run_op("R10 acc zero", 2, 0, 0, 0, 100, -50, 0, 0, 7, 3);
  endtask

  task automatic t_multiply();
    run_op("R2 mul a", 1, 0, 0, 0, 3000, -2000, 0, 0, 1500, 700);
    run_op("R2 mul b", 1, 0, 0, 0, -1234, 4321, 999, 999, -777, -5555);
    run_op("R1 R8 mul clip", 1, 0, 0, 0, -32768, -32768, 0, 0, -32768, -32768);
    run_op("R8 mul noclip", 1, 0, 0, 0, -32768, -32768, 0, 0, -32768, 32767);
  endtask

  task automatic t_butterfly();
    run_op("R3 bfly a", 0, 0, 0, 0, 12000, -8000, 5000, -3000, 23170, -23170);
    run_op("R3 bfly b", 0, 0, 0, 0, -32768, 32767, -32768, 32767, 32767, 0);
    run_op("R3 R8 bfly clip", 0, 0, 0, 0, -32768, -32768, 0, 32767, -32768, -32768);
  endtask

  task automatic t_addsub();
    run_op("R7 add", 3, 0, 0, 0, 1000, -2000, 300, 400, 5, 5);
    run_op("R7 sub", 3, 1, 0, 0, 1000, -2000, 300, 400, 5, 5);
    run_op("R7 add min", 3, 0, 0, 0, -32768, 32767, -32768, 32767, 0, 0);
    run_op("R7 sub edge", 3, 1, 0, 0, -32768, 32767, 32767, -32768, 0, 0);
  endtask

  task automatic t_mac();
    run_op("R5 mac load", 2, 0, 0, 1, 2000, 1000, 0, 0, 300, -400);
    run_op("R4 mac acc1", 2, 0, 0, 0, -1500, 2500, 0, 0, 1200, 800);
    run_op("R4 mac acc2", 2, 0, 0, 0, 32767, -32768, 0, 0, 100, 100);
    // other modes in between must leave the running sum untouched
    run_op("R11 mul between", 1, 0, 0, 0, 5, 6, 0, 0, 7, 8);
    run_op("R11 bfly between", 0, 0, 0, 0, 5, 6, 1, 2, 7, 8);
    run_op("R11 mac resume", 2, 0, 0, 0, 10, 20, 0, 0, 30, 40);
  endtask

  task automatic t_clear();
    clr_pulse();
    run_op("R6 after clr", 2, 0, 0, 0, 111, 222, 0, 0, 3, -4);
    run_op("R6 clr with mac", 2, 0, 1, 0, 500, 600, 0, 0, 7, 9);
    run_op("R6 after clr mac", 2, 0, 0, 0, 50, -60, 0, 0, 70, 80);
    run_op("R6 clr in mul", 1, 0, 1, 0, 9, 9, 0, 0, 9, 9);
    run_op("R6 after clr mul", 2, 0, 0, 0, 1, 2, 0, 0, 3, 4);
  endtask

  task automatic t_mac_sat();
    run_op("R8 macsat load", 2, 0, 0, 1, -32768, 0, 0, 0, -32768, 0);
    run_op("R8 macsat over", 2, 0, 0, 0, -32768, 0, 0, 0, -32768, 0);
    run_op("R8 macsat more", 2, 0, 0, 0, -32768, 0, 0, 0, -32768, 0);
    run_op("R8 macsat back1", 2, 0, 0, 0, -32768, 0, 0, 0, 32767, 0);
    run_op("R8 macsat back2", 2, 0, 0, 0, -32768, 0, 0, 0, 32767, 0);
  endtask

  task automatic t_hold();
    longint h0, h1;
    run_op("R9 pre hold", 0, 0, 0, 0, 400, 300, 200, 100, 1000, 2000);
    h0 = sx(y0_re); h1 = sx(y1_im);
    a_re = 16'h1234; b_im = 16'h7000; mode = 2'b01;
    repeat (3) @(negedge clk);
    chk("R9 hold out_valid", longint'(out_valid), 0);
    chk("R9 hold y0_re", sx(y0_re), h0);
    chk("R9 hold y1_im", sx(y1_im), h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_multiply();
    t_butterfly();
    t_addsub();
    t_mac();
    t_clear();
    t_mac_sat();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule